// File: doc/BRIEF.md
# Set-Once Watchdog Timer

This block is a watchdog that guards a processor against runaway software. Its timing base is a counter that runs at the system clock and spans 2^13 cycles. Software reaches it through a single byte-wide control register. Writing a one into the arm bit of that register switches the watchdog on. The same write also restarts the count, so it serves as the periodic service strobe as well.

Once armed, the watchdog cannot be switched off by any register write; only the block reset returns it to the idle state. If software lets a full period elapse without a service write, the block raises a one-cycle timeout pulse. It stays armed and starts counting the next period at once. While the core is halted in its stop state, the count is frozen. The timeout pulse is meant to feed the chip's reset generator, which lies outside this block.

Top module: `wdt_set_once`

## Requirements
- R1: While `rst_ni` is low, and right after it is released, `timeout_o` is 0 and a read of the control address returns 0x00.
- R2: A write whose address is 0x0C and whose data has bit 0 set arms the watchdog. Afterwards a read at 0x0C returns 0x01 (bit 0 = armed, all other bits 0).
- R3: A write at 0x0C with bit 0 clear, or a write to any other address, changes neither the armed state nor the running count, whether the watchdog is armed or not.
- R4: If the watchdog is armed and nothing else happens, `timeout_o` is high for exactly one cycle. That cycle is the one following the 8192nd rising edge after the arming write's edge.
- R5: Every arming write restarts the period. A service write on the very edge that would have produced the timeout suppresses that pulse and moves the next one a full period later.
- R6: After a timeout the watchdog stays armed, and the next pulse follows 8192 cycles later unless software services it.
- R7: Each rising edge with `halt_i` high leaves the count unchanged, so the timeout is delayed by exactly the number of halted edges.
- R8: While the watchdog is not armed, `timeout_o` never rises.
- R9: A read at any address other than 0x0C returns 0x00.
- R10: Asserting `rst_ni` low disarms the watchdog at once, even in the middle of a period. No timeout follows until a new arming write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 8 | Register read address |
| rd_data_o | output | 8 | Register read data (combinational) |
| halt_i | input | 1 | Core is in stop state; freezes the count |
| timeout_o | output | 1 | One-cycle watchdog expiry pulse |

## Verification
The hardest case to reach is a service write that lands on exactly the edge where the count would expire. Here the restart and the expiry compete in the same cycle. The bench keeps its own edge counter and derives each deadline from the edge of the arming write. It then places a service write precisely on the second periodic deadline and confirms that no pulse appears and that the next one is a full period later. A frozen window of known length during `halt_i`, and a reset in the middle of a period, are placed in the same way from that edge count.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic {
    WDT_IDLE  = 1'b0,
    WDT_ARMED = 1'b1
  } wdt_state_e;

  typedef struct packed {
    logic kick;  // write of one to the arm bit
    logic hit;   // any write to the control address
  } wdt_wr_s;

endpackage

// File: rtl/wdt_reg_port.sv
module wdt_reg_port
  import wdt_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CTRL_ADDR = 12,
  parameter int unsigned ARM_BIT   = 0
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              armed_i,
  output wdt_wr_s           wr_o,
  output logic [DATA_W-1:0] rd_data_o
);

  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

  logic rd_sel;

  always_comb begin
    wr_o.hit  = wr_en_i && (wr_addr_i == CTRL_A);
    wr_o.kick = wr_o.hit && wr_data_i[ARM_BIT];
  end

  assign rd_sel = (rd_addr_i == CTRL_A);

  for (genvar b = 0; b < DATA_W; b++) begin : g_rd
    if (b == ARM_BIT) begin : g_arm
      assign rd_data_o[b] = rd_sel & armed_i;
    end else begin : g_zero
      assign rd_data_o[b] = 1'b0;
    end
  end

endmodule

// File: rtl/wdt_arm_latch.sv
module wdt_arm_latch
  import wdt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kick_i,
  output logic armed_o
);

  wdt_state_e state_q, state_d;

  // sticky: only reset leaves ARMED
  always_comb begin
    state_d = state_q;
    if (kick_i) state_d = WDT_ARMED;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= WDT_IDLE;
    else         state_q <= state_d;
  end

  assign armed_o = (state_q == WDT_ARMED);

endmodule

// File: rtl/wdt_div_counter.sv
module wdt_div_counter #(
  parameter int unsigned DIV_LOG2 = 13
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic armed_i,
  input  logic kick_i,
  input  logic halt_i,
  output logic expire_o
);

  localparam int unsigned     CNT_W   = DIV_LOG2;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             exp_q;
  logic             advance;

  // service beats expiry in the same cycle
  assign advance = armed_i && !halt_i && !kick_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else if (kick_i) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else if (advance) begin
      cnt_q <= cnt_q + 1'b1;
      exp_q <= (cnt_q == CNT_MAX);
    end else begin
      exp_q <= 1'b0;
    end
  end

  assign expire_o = exp_q;

endmodule

// File: rtl/wdt_set_once.sv
module wdt_set_once
  import wdt_pkg::*;
#(
  parameter int unsigned DIV_LOG2  = 13,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CTRL_ADDR = 12,
  parameter int unsigned ARM_BIT   = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              halt_i,
  output logic              timeout_o
);

  wdt_wr_s wr;
  logic    armed;

  wdt_reg_port #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .CTRL_ADDR(CTRL_ADDR),
    .ARM_BIT  (ARM_BIT)
  ) u_reg (
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .rd_addr_i(rd_addr_i),
    .armed_i  (armed),
    .wr_o     (wr),
    .rd_data_o(rd_data_o)
  );

  wdt_arm_latch u_arm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .kick_i (wr.kick),
    .armed_o(armed)
  );

  wdt_div_counter #(
    .DIV_LOG2(DIV_LOG2)
  ) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .armed_i (armed),
    .kick_i  (wr.kick),
    .halt_i  (halt_i),
    .expire_o(timeout_o)
  );

endmodule

// File: rtl/wdt_set_once_chk.sv
module wdt_set_once_chk #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CTRL_ADDR = 12,
  parameter int unsigned ARM_BIT   = 0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              halt_i,
  input logic              armed_i,
  input logic              timeout_o
);

  logic svc;
  assign svc = wr_en_i && (wr_addr_i == ADDR_W'(CTRL_ADDR)) && wr_data_i[ARM_BIT];

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_idle: assert (!armed_i && !timeout_o)
        else $error("reset state violated");
    end
  end

  a_r2_arm_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc |=> armed_i);

  a_r3_arm_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_i |=> armed_i);

  a_r4_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> !timeout_o);

  a_r5_service_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc |=> !timeout_o);

  a_r7_halt_freezes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i |=> !timeout_o);

  a_r8_idle_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_i |-> !timeout_o);

endmodule

bind wdt_set_once wdt_set_once_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .CTRL_ADDR(CTRL_ADDR),
  .ARM_BIT  (ARM_BIT)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .wr_addr_i(wr_addr_i),
  .wr_data_i(wr_data_i),
  .halt_i   (halt_i),
  .armed_i  (armed),
  .timeout_o(timeout_o)
);

// File: tb/wdt_set_once_tb_top.sv
module wdt_set_once_tb_top;

  localparam int unsigned PERIOD = 8192;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] rd_addr_i = '0;
  logic [7:0] rd_data_o;
  logic       halt_i = 1'b0;
  logic       timeout_o;

  int unsigned cyc = 0;
  int unsigned checks = 0;
  int unsigned errors = 0;
  int unsigned unexp = 0;
  bit          done = 1'b0;

  int unsigned exp_q[$];
  string       tag_q[$];

  always #10 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  wdt_set_once dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .halt_i(halt_i), .timeout_o(timeout_o)
  );

  // monitor: compare pulses against the expected-cycle queue
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      if (exp_q.size() > 0 && exp_q[0] == cyc) begin
        checks++;
        if (timeout_o !== 1'b1) begin
          errors++;
          $display("FAIL %s: timeout at cycle %0d actual %b expected 1", tag_q[0], cyc, timeout_o);
        end
        void'(exp_q.pop_front());
        void'(tag_q.pop_front());
      end else if (timeout_o !== 1'b0) begin
        checks++; errors++; unexp++;
        $display("FAIL R4/R8: unexpected timeout at cycle %0d actual %b expected 0", cyc, timeout_o);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d, output int unsigned w);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(posedge clk_i); #1;
    w = cyc;
    wr_en_i = 1'b0; wr_data_i = '0;
  endtask

  task automatic read_chk(input string tag, input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk_i);
    rd_addr_i = a; #1;
    chk(tag, {24'd0, rd_data_o}, {24'd0, exp});
  endtask

  task automatic goto(input int unsigned n);
    while (cyc < n) @(negedge clk_i);
  endtask

  task automatic expect_at(input int unsigned c, input string tag);
    exp_q.push_back(c);
    tag_q.push_back(tag);
  endtask

  task automatic flush();
    exp_q.delete();
    tag_q.delete();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    int unsigned w, s, base, u0;
    // R1 reset state
    repeat (3) @(posedge clk_i);
    #1;
    chk("R1 in reset", {31'd0, timeout_o}, 32'd0);
    @(negedge clk_i); rst_ni = 1'b1;
    chk("R1 after release", {31'd0, timeout_o}, 32'd0);
    read_chk("R1 status", 8'h0C, 8'h00);

    // R3 and R8: writes that must not arm
    do_write(8'h0C, 8'h00, w);
    do_write(8'h0D, 8'h01, w);
    do_write(8'h0C, 8'hFE, w);
    read_chk("R3 unarmed status", 8'h0C, 8'h00);
    u0 = unexp;
    goto(cyc + PERIOD + 800);
    chk("R8 no pulse unarmed", unexp, u0);

    // R2 arm, R9 other address
    do_write(8'h0C, 8'h01, w);
    expect_at(w + PERIOD, "R4");
    read_chk("R2 armed status", 8'h0C, 8'h01);
    read_chk("R9 other addr", 8'h0D, 8'h00);
    read_chk("R9 other addr", 8'hFF, 8'h00);

    // R3: disarm attempt and foreign write mid-period; deadline unchanged
    goto(w + 4000);
    do_write(8'h0C, 8'h00, s);
    do_write(8'h0D, 8'hFF, s);
    read_chk("R3 still armed", 8'h0C, 8'h01);

    // R6 stays armed, periodic
    expect_at(w + 2 * PERIOD, "R6");
    goto(w + PERIOD + 2);
    read_chk("R6 armed after timeout", 8'h0C, 8'h01);

    // R5: service exactly on the second deadline edge
    goto(w + 2 * PERIOD - 2);
    do_write(8'h0C, 8'h01, s);
    chk("R5 service edge", s, w + 2 * PERIOD);
    flush();
    expect_at(s + PERIOD, "R5");

    // R7: halt for 500 edges
    goto(s + 100);
    @(negedge clk_i); halt_i = 1'b1;
    repeat (500) @(negedge clk_i);
    halt_i = 1'b0;
    flush();
    expect_at(s + PERIOD + 500, "R7");
    goto(s + PERIOD + 520);
    chk("R7 pulse consumed", exp_q.size(), 0);

    // R10: reset mid-period
    base = cyc;
    goto(base + 3000);
    flush();
    @(negedge clk_i); rst_ni = 1'b0; #1;
    read_chk("R10 disarmed in reset", 8'h0C, 8'h00);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    read_chk("R10 disarmed after reset", 8'h0C, 8'h00);
    u0 = unexp;
    goto(cyc + PERIOD + 500);
    chk("R10 no pulse after reset", unexp, u0);

    // R10 re-arm works after reset
    do_write(8'h0C, 8'h81, w);
    expect_at(w + PERIOD, "R10");
    read_chk("R2 rearm status", 8'h0C, 8'h01);
    goto(w + PERIOD + 5);
    chk("R10 rearm pulse consumed", exp_q.size(), 0);

    finish_run();
  end

endmodule